// File: doc/BRIEF.md
# Macroblock Overlay Priority Selector

This block decides, once for every 8x8 output macroblock, which image layer supplies that block's pixels. The caller presents a block coordinate in block units: a column index and a row index. The block compares it against the rectangles of up to eight overlay regions and one primary source plane. It returns a layer code one cycle later. A pixel combiner further down the pipeline uses that code, together with the operation class of the winning overlay, to merge the overlay with the primary plane or with the background colour.

Every region is placed in whole macroblock units, so coverage is a pure integer comparison and never involves pixel offsets. When several enabled overlays claim the same block, only the lowest-numbered one is reported. Overlays are never combined with one another. The primary plane ranks below every overlay, and the background colour is the fallback when nothing else covers the block. Region registers are loaded through a small synchronous write port.

Top module: `mb_layer_select`

## Requirements
- R1: After reset, `sel_valid` is 0 and every region register is cleared. With all registers cleared, every probed block reports the background code 9 with operation class 0.
- R2: A write with `wr_en`=1 addresses a region with `wr_layer`: 0 to 7 select overlays and 8 selects the primary plane. `wr_field` selects the register: 0 is X base, 1 is Y base, 2 is width, 3 is height, 4 is control. In the control register, bit 0 is the enable and bits 2:1 are the operation class (0 alpha blend, 1 colour key, 2 raster operation). The primary plane has no control register.
- R3: A region covers block (x,y) when xbase <= x < xbase+width and ybase <= y < ybase+height. The sums are taken without wrap-around.
- R4: A region whose width or height is 0 covers no block.
- R5: When several enabled overlays cover a block, the output code is the lowest index among them.
- R6: An overlay whose enable bit is 0 is ignored, even when its rectangle covers the block.
- R7: When no enabled overlay covers a block and the primary plane does, the output code is 8.
- R8: When neither an enabled overlay nor the primary plane covers a block, the output code is 9.
- R9: `sel_op` carries the operation class of the selected overlay. It is 0 when the code is 8 or 9.
- R10: The result for a coordinate presented with `blk_valid`=1 appears on the outputs after one rising edge, with `sel_valid`=1. A cycle with `blk_valid`=0 gives `sel_valid`=0 on the next cycle.
- R11: Writes with `wr_layer` 9 to 15, writes with `wr_field` 5 to 7, and control writes to layer 8 change no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_layer | input | 4 | Region address: 0-7 overlays, 8 primary plane |
| wr_field | input | 3 | Register within the region |
| wr_data | input | CW (8) | Write value |
| blk_valid | input | 1 | Block coordinate is valid this cycle |
| blk_x | input | CW (8) | Block column index |
| blk_y | input | CW (8) | Block row index |
| sel_valid | output | 1 | Result valid |
| sel_layer | output | 4 | Layer code: 0-7 overlay, 8 primary, 9 background |
| sel_op | output | 2 | Operation class of the selected overlay |

## Verification
The assertions check four properties on every cycle. The valid flag follows the input one cycle later. A hit on overlay 0 always wins. Any enabled overlay hit keeps the primary and background codes off the output. A block with no hit at all gives the background code. Only the bench scenarios can show that the rectangle bounds are exact, including zero sizes and sums past the coordinate range. The same holds for the reported operation class matching the programmed one, for ignored writes leaving the layout unchanged, and for the full priority order between overlays other than overlay 0.

// File: rtl/mb_layer_select.sv
module mb_layer_select #(
  parameter int NUM_OVL = 8,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_layer,
  input  logic [2:0]    wr_field,
  input  logic [CW-1:0] wr_data,
  input  logic          blk_valid,
  input  logic [CW-1:0] blk_x,
  input  logic [CW-1:0] blk_y,
  output logic          sel_valid,
  output logic [3:0]    sel_layer,
  output logic [1:0]    sel_op
);
  localparam int NREG = NUM_OVL + 1;
  localparam logic [3:0] CODE_PRI = 4'd8;
  localparam logic [3:0] CODE_BG  = 4'd9;

  logic [CW-1:0] bx [NREG];
  logic [CW-1:0] by [NREG];
  logic [CW-1:0] bw [NREG];
  logic [CW-1:0] bh [NREG];
  logic [NUM_OVL-1:0] ovl_en;
  logic [1:0]    ovl_op [NUM_OVL];
  logic [NREG-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      localparam logic [3:0] ADDR = (g == NUM_OVL) ? CODE_PRI : 4'(g);
      logic sel;
      logic [CW:0] xe, ye;
      logic en;
      assign sel = wr_en && (wr_layer == ADDR);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bx[g] <= '0; by[g] <= '0; bw[g] <= '0; bh[g] <= '0;
        end else if (sel) begin
          case (wr_field)
            3'd0: bx[g] <= wr_data;
            3'd1: by[g] <= wr_data;
            3'd2: bw[g] <= wr_data;
            3'd3: bh[g] <= wr_data;
            default: ;
          endcase
        end
      end

      if (g < NUM_OVL) begin : g_ctl
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            ovl_en[g] <= 1'b0;
            ovl_op[g] <= 2'd0;
          end else if (sel && wr_field == 3'd4) begin
            ovl_en[g] <= wr_data[0];
            ovl_op[g] <= wr_data[2:1];
          end
        end
        assign en = ovl_en[g];
      end else begin : g_pri
        assign en = 1'b1;
      end

      assign xe = {1'b0, bx[g]} + {1'b0, bw[g]};
      assign ye = {1'b0, by[g]} + {1'b0, bh[g]};
      assign hit[g] = en
                   && ({1'b0, blk_x} >= {1'b0, bx[g]}) && ({1'b0, blk_x} < xe)
                   && ({1'b0, blk_y} >= {1'b0, by[g]}) && ({1'b0, blk_y} < ye);
    end
  endgenerate

  logic [3:0] nxt_layer;
  logic [1:0] nxt_op;
  always_comb begin
    nxt_layer = hit[NUM_OVL] ? CODE_PRI : CODE_BG;
    nxt_op    = 2'd0;
    for (int i = NUM_OVL - 1; i >= 0; i--) begin
      if (hit[i]) begin
        nxt_layer = 4'(i);
        nxt_op    = ovl_op[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_layer <= CODE_BG;
      sel_op    <= 2'd0;
    end else begin
      sel_valid <= blk_valid;
      if (blk_valid) begin
        sel_layer <= nxt_layer;
        sel_op    <= nxt_op;
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> sel_valid);
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> !sel_valid);
  assert_ovl0_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && hit[0] |=> sel_layer == 4'd0);
  assert_ovl_beats_primary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && (|hit[NUM_OVL-1:0]) |=> sel_layer < CODE_PRI);
  assert_bg_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && hit == '0 |=> sel_layer == CODE_BG && sel_op == 2'd0);
endmodule

// File: tb/tb_mb_layer_select.sv
module tb_mb_layer_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_layer = '0;
  logic [2:0] wr_field = '0;
  logic [7:0] wr_data = '0;
  logic blk_valid = 1'b0;
  logic [7:0] blk_x = '0, blk_y = '0;
  logic sel_valid;
  logic [3:0] sel_layer;
  logic [1:0] sel_op;

  int checks = 0, fails = 0;
  int m_bx[9], m_by[9], m_bw[9], m_bh[9], m_en[8], m_op[8];

  always #2.5 clk = ~clk;

  mb_layer_select dut (.*);

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic bit covers(int r, int x, int y);
    return x >= m_bx[r] && x < m_bx[r] + m_bw[r] && y >= m_by[r] && y < m_by[r] + m_bh[r];
  endfunction

  function automatic int exp_layer(int x, int y);
    for (int i = 0; i < 8; i++) if (m_en[i] != 0 && covers(i, x, y)) return i;
    if (covers(8, x, y)) return 8;
    return 9;
  endfunction

  function automatic int exp_op(int x, int y);
    int l = exp_layer(x, y);
    return (l < 8) ? m_op[l] : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int l, int f, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_layer = 4'(l); wr_field = 3'(f); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (l <= 8 && f <= 3) begin
      case (f)
        0: m_bx[l] = d & 255;
        1: m_by[l] = d & 255;
        2: m_bw[l] = d & 255;
        default: m_bh[l] = d & 255;
      endcase
    end else if (l < 8 && f == 4) begin
      m_en[l] = d & 1;
      m_op[l] = (d >> 1) & 3;
    end
  endtask

  task automatic region(int l, int x, int y, int w, int h);
    wr(l, 0, x); wr(l, 1, y); wr(l, 2, w); wr(l, 3, h);
  endtask

  task automatic probe(string tag, int x, int y);
    @(negedge clk);
    blk_valid = 1'b1; blk_x = 8'(x); blk_y = 8'(y);
    @(negedge clk);
    blk_valid = 1'b0;
    chk({tag, " valid R10"}, sel_valid, 1);
    chk({tag, " layer"}, sel_layer, exp_layer(x, y));
    chk({tag, " op R9"}, sel_op, exp_op(x, y));
  endtask

  task automatic sweep(string tag);
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 6; x++) probe(tag, x, y);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 9; i++) begin
      m_bx[i] = 0; m_by[i] = 0; m_bw[i] = 0; m_bh[i] = 0;
      if (i < 8) begin m_en[i] = 0; m_op[i] = 0; end
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", sel_valid, 0);
    rst_n = 1'b1;
    sweep("R1 reset grid");

    region(0, 1, 3, 2, 2); wr(0, 4, 1);
    region(1, 4, 0, 1, 5); wr(1, 4, 5);
    region(2, 2, 3, 4, 1); wr(2, 4, 3);
    region(8, 0, 1, 6, 3);
    sweep("R2/R3/R5/R7/R8 grid A");

    @(negedge clk);
    chk("R10 idle valid", sel_valid, 0);

    region(5, 0, 0, 6, 5); wr(5, 4, 2);
    sweep("R5 grid with wide overlay 5");
    wr(0, 4, 0);
    sweep("R6 overlay 0 disabled");
    wr(1, 2, 0);
    probe("R4 zero width", 4, 0);
    wr(5, 3, 0);
    probe("R4 zero height", 0, 0);
    probe("R4 zero height primary covers", 0, 2);

    wr(12, 2, 200); wr(9, 0, 0); wr(2, 6, 0); wr(8, 4, 0); wr(3, 5, 255);
    sweep("R11 ignored writes");

    region(3, 250, 250, 10, 10); wr(3, 4, 7);
    probe("R3 top edge", 255, 255);
    probe("R3 below base", 249, 255);

    for (int r = 0; r < 20; r++) begin
      for (int k = 0; k < 6; k++) begin
        int l = $urandom_range(0, 15);
        int f = $urandom_range(0, 7);
        wr(l, f, (f == 4) ? $urandom_range(0, 7) : $urandom_range(0, 12));
      end
      for (int k = 0; k < 25; k++)
        probe("R3/R5/R6/R7/R8 random", $urandom_range(0, 15), $urandom_range(0, 15));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule